// File: doc/BRIEF.md
# Multi-Channel Driver Fault Latch and Mask Controller

This block manages the fault state of a group of solenoid driver channels (three by default). For each channel it receives synchronous comparator outputs for over-temperature, overcurrent, undervoltage, under-current and an off-state load comparator. It holds the channel's enable bit and its current setpoint register, which software writes through strobes. It also receives one diagnosis-register read strobe that is shared by all channels. The block latches each fault into a status bit and clears that bit on a diagnosis read, using a rule that depends on the fault type. On a protective trip (overcurrent, or an under-current that outlasts a debounce delay) it switches the channel off.

Each channel runs a small recovery state machine with four states. `ST_RUN` is normal operation. `ST_WAIT_RD` is entered from `ST_RUN` on a trip and left on a diagnosis read. `ST_WAIT_EN` is left when an enable bit of 1 is written. `ST_WAIT_SP` returns to `ST_WAIT_EN` if the enable bit is written to 0, and returns to `ST_RUN` when a nonzero setpoint is written. A registered, active-low fault pin combines the masked per-channel fault bits with an optional term driven by the external enable pin.

Top module: `drv_fault_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every setpoint is 0, every fault and off-state status bit is 0, and `fault_n` is 1.
- R2: In `ST_RUN`, a write strobe on the enable bit or the setpoint updates that register at the next clock edge. A channel drives (`ch_on`=1) only in `ST_RUN` with its enable bit at 1 and its setpoint nonzero.
- R3: A high overcurrent input is acted on only while `ch_on` is 1. It then sets the overcurrent bit, clears the enable bit and the setpoint, and moves the channel to `ST_WAIT_RD`, all at the next edge. While `ch_on` is 0 the input has no effect.
- R4: A diagnosis read clears the overcurrent bit even when the overcurrent input is still high.
- R5: The under-current bit sets, and the channel trips as in R3, after the under-current input has been high on UC_DELAY+1 consecutive cycles with `ch_on` at 1. A low cycle, or `ch_on` at 0, restarts the count.
- R6: A diagnosis read clears the under-current bit only if the under-current input is low in that cycle.
- R7: The over-temperature and undervoltage bits set while their inputs are high. A read clears them only when the input is low. They never switch the channel off.
- R8: A fault event in the same cycle as a diagnosis read leaves its bit set after the read.
- R9: In `ST_WAIT_RD`, writes to the enable bit and the setpoint are ignored. In `ST_WAIT_EN`, setpoint writes are ignored. The channel returns to `ST_RUN` only after a read, then an enable write of 1, then a nonzero setpoint write.
- R10: `fault_n` goes low one cycle after a latched fault bit (over-temperature, overcurrent, undervoltage or under-current) is 1 on a channel whose mask bit is 1. Channels whose mask bit is 0 have no effect on it.
- R11: With `cfg_en_pin_mask` at 1, `fault_n` is 0 one cycle after `en_pin` is 0. With `cfg_en_pin_mask` at 0, `en_pin` has no effect.
- R12: A channel's `off_open_stat` bit is the off-state comparator input, registered, while that channel's setpoint is 0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | External enable pin level |
| cfg_en_pin_mask | input | 1 | 1: low `en_pin` forces `fault_n` low |
| cfg_ch_mask | input | NUM_CH | Per-channel fault-pin mask bits |
| ot_in | input | NUM_CH | Over-temperature comparators |
| oc_in | input | NUM_CH | Overcurrent comparators |
| uv_in | input | NUM_CH | Undervoltage comparators |
| uc_in | input | NUM_CH | Current-below-threshold comparators |
| off_open_in | input | NUM_CH | Off-state comparators (1 = open load, 0 = bypass) |
| diag_rd | input | 1 | Diagnosis register read strobe |
| en_wr | input | NUM_CH | Enable bit write strobes |
| en_wdata | input | NUM_CH | Enable bit write data |
| sp_wr | input | NUM_CH | Setpoint write strobes |
| sp_wdata | input | NUM_CH*SP_W | Setpoint write data, channel 0 in the low bits |
| ch_en | output | NUM_CH | Enable bit registers |
| ch_sp | output | NUM_CH*SP_W | Setpoint registers, channel 0 in the low bits |
| ch_on | output | NUM_CH | Channel allowed to drive |
| flt_ot | output | NUM_CH | Latched over-temperature bits |
| flt_oc | output | NUM_CH | Latched overcurrent bits |
| flt_uv | output | NUM_CH | Latched undervoltage bits |
| flt_uc | output | NUM_CH | Latched under-current bits |
| off_open_stat | output | NUM_CH | Off-state open-load status |
| fault_n | output | 1 | Registered active-low fault pin |

## Verification
The hardest situations to reach from the ports are those that depend on exact cycle alignment. One is the under-current count that stops one cycle short of expiry. Another is a fault event that lands in the same cycle as a diagnosis read. The stimulus holds the under-current input for exactly UC_DELAY cycles, drops it for one cycle, and raises it again, which shows that the count restarts. It then holds the input for UC_DELAY+1 cycles to get the trip. For the collision case, the overcurrent input and the read strobe are raised on the same negative edge. Each recovery step is then tried out of order, and the enable and setpoint registers are checked to show which writes were ignored.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_WAIT_RD = 2'd1,
        ST_WAIT_EN = 2'd2,
        ST_WAIT_SP = 2'd3
    } chan_state_e;
endpackage

// File: rtl/drv_fault_debounce.sv
module drv_fault_debounce #(
    parameter int UC_DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic low,
    output logic expire
);
    localparam int CNT_W = $clog2(UC_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(UC_DELAY);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!arm || !low)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = arm && low && (cnt_q == CNT_MAX);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !low |=> cnt_q == '0);
endmodule

// File: rtl/drv_fault_chan.sv
module drv_fault_chan
    import drv_fault_pkg::*;
#(
    parameter int SP_W     = 8,
    parameter int UC_DELAY = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ot_in,
    input  logic            oc_in,
    input  logic            uv_in,
    input  logic            uc_in,
    input  logic            off_open_in,
    input  logic            diag_rd,
    input  logic            en_wr,
    input  logic            en_wdata,
    input  logic            sp_wr,
    input  logic [SP_W-1:0] sp_wdata,
    output logic            en_q,
    output logic [SP_W-1:0] sp_q,
    output logic            on,
    output logic            ot_q,
    output logic            oc_q,
    output logic            uv_q,
    output logic            uc_q,
    output logic            off_stat_q
);
    chan_state_e state_q, state_d;
    logic        oc_evt, uc_evt, trip;
    logic        en_ok, sp_ok;

    assign on     = (state_q == ST_RUN) && en_q && (sp_q != '0);
    assign oc_evt = on && oc_in;
    assign trip   = oc_evt || uc_evt;

    drv_fault_debounce #(.UC_DELAY(UC_DELAY)) i_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (on),
        .low    (uc_in),
        .expire (uc_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (trip) state_d = ST_WAIT_RD;
            ST_WAIT_RD: if (diag_rd) state_d = ST_WAIT_EN;
            ST_WAIT_EN: if (en_wr && en_wdata) state_d = ST_WAIT_SP;
            ST_WAIT_SP: begin
                if (en_wr && !en_wdata)
                    state_d = ST_WAIT_EN;
                else if (sp_wr && (sp_wdata != '0))
                    state_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        en_ok = 1'b0;
        sp_ok = 1'b0;
        unique case (state_q)
            ST_RUN:     begin en_ok = 1'b1; sp_ok = 1'b1; end
            ST_WAIT_RD: begin en_ok = 1'b0; sp_ok = 1'b0; end
            ST_WAIT_EN: begin en_ok = 1'b1; sp_ok = 1'b0; end
            ST_WAIT_SP: begin en_ok = 1'b1; sp_ok = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            sp_q       <= '0;
            ot_q       <= 1'b0;
            oc_q       <= 1'b0;
            uv_q       <= 1'b0;
            uc_q       <= 1'b0;
            off_stat_q <= 1'b0;
        end else begin
            if (trip) begin
                en_q <= 1'b0;
                sp_q <= '0;
            end else begin
                if (en_wr && en_ok) en_q <= en_wdata;
                if (sp_wr && sp_ok) sp_q <= sp_wdata;
            end
            if (ot_in)                 ot_q <= 1'b1;
            else if (diag_rd)          ot_q <= 1'b0;
            if (uv_in)                 uv_q <= 1'b1;
            else if (diag_rd)          uv_q <= 1'b0;
            if (oc_evt)                oc_q <= 1'b1;
            else if (diag_rd)          oc_q <= 1'b0;
            if (uc_evt)                uc_q <= 1'b1;
            else if (diag_rd && !uc_in) uc_q <= 1'b0;
            off_stat_q <= (sp_q == '0) && off_open_in;
        end
    end

    // R3
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> !en_q && (sp_q == '0) && (state_q == ST_WAIT_RD));

    // R4
    oc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_rd && !oc_evt) |=> !oc_q);

    // R8
    oc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_evt |=> oc_q);

    // R9
    hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RD && !diag_rd) |=> (state_q == ST_WAIT_RD) && !en_q);

    // R2
    on_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> (state_q == ST_RUN) && en_q);
endmodule

// File: rtl/drv_fault_pin.sv
module drv_fault_pin #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pin,
    input  logic              mask_en,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic [NUM_CH-1:0] ch_fault,
    output logic              fault_n
);
    logic en_term, ch_term;

    assign en_term = mask_en && !en_pin;
    assign ch_term = |(ch_mask & ch_fault);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fault_n <= 1'b1;
        else
            fault_n <= !(en_term || ch_term);
    end

    // R11
    en_pin_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && !en_pin) |=> !fault_n);

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_en && ((ch_mask & ch_fault) == '0)) |=> fault_n);
endmodule

// File: rtl/drv_fault_ctrl.sv
module drv_fault_ctrl #(
    parameter int NUM_CH   = 3,
    parameter int SP_W     = 8,
    parameter int UC_DELAY = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_pin,
    input  logic                   cfg_en_pin_mask,
    input  logic [NUM_CH-1:0]      cfg_ch_mask,
    input  logic [NUM_CH-1:0]      ot_in,
    input  logic [NUM_CH-1:0]      oc_in,
    input  logic [NUM_CH-1:0]      uv_in,
    input  logic [NUM_CH-1:0]      uc_in,
    input  logic [NUM_CH-1:0]      off_open_in,
    input  logic                   diag_rd,
    input  logic [NUM_CH-1:0]      en_wr,
    input  logic [NUM_CH-1:0]      en_wdata,
    input  logic [NUM_CH-1:0]      sp_wr,
    input  logic [NUM_CH*SP_W-1:0] sp_wdata,
    output logic [NUM_CH-1:0]      ch_en,
    output logic [NUM_CH*SP_W-1:0] ch_sp,
    output logic [NUM_CH-1:0]      ch_on,
    output logic [NUM_CH-1:0]      flt_ot,
    output logic [NUM_CH-1:0]      flt_oc,
    output logic [NUM_CH-1:0]      flt_uv,
    output logic [NUM_CH-1:0]      flt_uc,
    output logic [NUM_CH-1:0]      off_open_stat,
    output logic                   fault_n
);
    logic [NUM_CH-1:0] any_flt;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        drv_fault_chan #(.SP_W(SP_W), .UC_DELAY(UC_DELAY)) i_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .ot_in       (ot_in[g]),
            .oc_in       (oc_in[g]),
            .uv_in       (uv_in[g]),
            .uc_in       (uc_in[g]),
            .off_open_in (off_open_in[g]),
            .diag_rd     (diag_rd),
            .en_wr       (en_wr[g]),
            .en_wdata    (en_wdata[g]),
            .sp_wr       (sp_wr[g]),
            .sp_wdata    (sp_wdata[g*SP_W +: SP_W]),
            .en_q        (ch_en[g]),
            .sp_q        (ch_sp[g*SP_W +: SP_W]),
            .on          (ch_on[g]),
            .ot_q        (flt_ot[g]),
            .oc_q        (flt_oc[g]),
            .uv_q        (flt_uv[g]),
            .uc_q        (flt_uc[g]),
            .off_stat_q  (off_open_stat[g])
        );
        assign any_flt[g] = flt_ot[g] | flt_oc[g] | flt_uv[g] | flt_uc[g];
    end

    drv_fault_pin #(.NUM_CH(NUM_CH)) i_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_pin   (en_pin),
        .mask_en  (cfg_en_pin_mask),
        .ch_mask  (cfg_ch_mask),
        .ch_fault (any_flt),
        .fault_n  (fault_n)
    );
endmodule

// File: tb/test_drv_fault_ctrl.sv
module test_drv_fault_ctrl;
    localparam int NC  = 3;
    localparam int SW  = 8;
    localparam int DLY = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b1, cfg_en_pin_mask = 1'b0, diag_rd = 1'b0;
    logic [NC-1:0] cfg_ch_mask = '0, ot_in = '0, oc_in = '0, uv_in = '0, uc_in = '0;
    logic [NC-1:0] off_open_in = '0, en_wr = '0, en_wdata = '0, sp_wr = '0;
    logic [NC*SW-1:0] sp_wdata = '0;
    logic [NC-1:0] ch_en, ch_on, flt_ot, flt_oc, flt_uv, flt_uc, off_open_stat;
    logic [NC*SW-1:0] ch_sp;
    logic fault_n;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    drv_fault_ctrl #(.NUM_CH(NC), .SP_W(SW), .UC_DELAY(DLY)) i_drv_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .cfg_en_pin_mask(cfg_en_pin_mask),
        .cfg_ch_mask(cfg_ch_mask), .ot_in(ot_in), .oc_in(oc_in), .uv_in(uv_in),
        .uc_in(uc_in), .off_open_in(off_open_in), .diag_rd(diag_rd), .en_wr(en_wr),
        .en_wdata(en_wdata), .sp_wr(sp_wr), .sp_wdata(sp_wdata), .ch_en(ch_en),
        .ch_sp(ch_sp), .ch_on(ch_on), .flt_ot(flt_ot), .flt_oc(flt_oc),
        .flt_uv(flt_uv), .flt_uc(flt_uc), .off_open_stat(off_open_stat),
        .fault_n(fault_n)
    );

    // {mask_en, en_pin, ch_mask[2:0], ot_in[2:0], expected fault_n}
    localparam logic [8:0] PIN_VEC [7] = '{
        9'b0_1_111_000_1,
        9'b0_1_111_010_0,
        9'b0_1_101_010_1,
        9'b1_0_000_000_0,
        9'b0_0_111_000_1,
        9'b0_1_001_001_0,
        9'b1_1_000_111_1
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_en(input int ch, input logic v);
        en_wr[ch] = 1'b1; en_wdata[ch] = v;
        tick();
        en_wr[ch] = 1'b0;
    endtask

    task automatic wr_sp(input int ch, input logic [SW-1:0] v);
        sp_wr[ch] = 1'b1; sp_wdata[ch*SW +: SW] = v;
        tick();
        sp_wr[ch] = 1'b0;
    endtask

    task automatic rd();
        diag_rd = 1'b1;
        tick();
        diag_rd = 1'b0;
    endtask

    function automatic logic [SW-1:0] sp_of(input int ch);
        return ch_sp[ch*SW +: SW];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 en", 32'(ch_en), 0);
        chk("R1 sp", 32'(ch_sp), 0);
        chk("R1 flags", 32'({flt_ot, flt_oc, flt_uv, flt_uc, off_open_stat}), 0);
        chk("R1 fault_n", 32'(fault_n), 1);
        rst_n = 1'b1;
        tick();

        // R2 writes in run
        wr_en(0, 1'b1);
        wr_sp(0, 8'h40);
        chk("R2 en", 32'(ch_en[0]), 1);
        chk("R2 sp", 32'(sp_of(0)), 32'h40);
        chk("R2 on", 32'(ch_on[0]), 1);

        // R3 overcurrent ignored on idle channel 1
        oc_in[1] = 1'b1; tick(); oc_in[1] = 1'b0;
        chk("R3 idle ignore", 32'(flt_oc[1]), 0);
        // R3 trip on channel 0
        oc_in[0] = 1'b1; tick();
        chk("R3 oc bit", 32'(flt_oc[0]), 1);
        chk("R3 en cleared", 32'(ch_en[0]), 0);
        chk("R3 sp cleared", 32'(sp_of(0)), 0);

        // R9 writes ignored before read
        wr_en(0, 1'b1);
        wr_sp(0, 8'h05);
        chk("R9 en held", 32'(ch_en[0]), 0);
        chk("R9 sp held", 32'(sp_of(0)), 0);
        // R4 read clears oc even with input high
        rd();
        chk("R4 oc cleared", 32'(flt_oc[0]), 0);
        oc_in[0] = 1'b0;
        wr_sp(0, 8'h09);
        chk("R9 sp before en", 32'(sp_of(0)), 0);
        wr_en(0, 1'b1);
        chk("R9 en accepted", 32'(ch_en[0]), 1);
        chk("R9 not on yet", 32'(ch_on[0]), 0);
        wr_sp(0, 8'h09);
        chk("R9 rearmed", 32'(ch_on[0]), 1);

        // R8 event and read in the same cycle
        oc_in[0] = 1'b1; diag_rd = 1'b1; tick(); oc_in[0] = 1'b0; diag_rd = 1'b0;
        chk("R8 set wins", 32'(flt_oc[0]), 1);
        rd();
        chk("R8 later read clears", 32'(flt_oc[0]), 0);
        wr_en(0, 1'b1);
        wr_sp(0, 8'h20);

        // R5 debounce restart then trip
        uc_in[0] = 1'b1; repeat (DLY) tick();
        uc_in[0] = 1'b0; tick();
        uc_in[0] = 1'b1; repeat (DLY) tick();
        chk("R5 no early trip", 32'(flt_uc[0]), 0);
        chk("R5 still on", 32'(ch_on[0]), 1);
        tick();
        chk("R5 uc set", 32'(flt_uc[0]), 1);
        chk("R5 disabled", 32'({ch_en[0], sp_of(0)}), 0);
        // R6 clear only when condition gone
        rd();
        chk("R6 kept while low current", 32'(flt_uc[0]), 1);
        uc_in[0] = 1'b0;
        rd();
        chk("R6 cleared", 32'(flt_uc[0]), 0);

        // R7 over-temperature and undervoltage, no trip
        wr_en(2, 1'b1);
        wr_sp(2, 8'h03);
        ot_in[2] = 1'b1; uv_in[1] = 1'b1; tick();
        chk("R7 ot set", 32'(flt_ot[2]), 1);
        chk("R7 uv set", 32'(flt_uv[1]), 1);
        chk("R7 no trip", 32'(ch_on[2]), 1);
        rd();
        chk("R7 ot kept", 32'(flt_ot[2]), 1);
        ot_in[2] = 1'b0; uv_in[1] = 1'b0;
        rd();
        chk("R7 cleared", 32'({flt_ot[2], flt_uv[1]}), 0);

        // R10 R11 fault pin vectors
        foreach (PIN_VEC[i]) begin
            cfg_en_pin_mask = PIN_VEC[i][8];
            en_pin          = PIN_VEC[i][7];
            cfg_ch_mask     = PIN_VEC[i][6:4];
            ot_in           = PIN_VEC[i][3:1];
            tick();
            tick();
            chk($sformatf("R10 R11 vector %0d", i), 32'(fault_n), 32'(PIN_VEC[i][0]));
            ot_in = '0; cfg_en_pin_mask = 1'b0; en_pin = 1'b1;
            rd();
            tick();
        end
        chk("R10 idle high", 32'(fault_n), 1);

        // R12 off-state status
        off_open_in[1] = 1'b1; tick();
        chk("R12 open while off", 32'(off_open_stat[1]), 1);
        wr_sp(1, 8'h07);
        tick();
        chk("R12 zero when sp set", 32'(off_open_stat[1]), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule